// File: doc/BRIEF.md
# Reset Release and Vector Sequencer

This block turns the raw external reset pin of a small 8-bit processor into a clean internal reset. It also starts the core at its programmed entry point. The pin is first synchronised and qualified against a minimum low width, so that short glitches have no effect. A qualified low holds the internal reset and preloads a prescaler and two cascaded down-counters. Once the pin is high again, the counters run from the oscillator clock. The second counter's underflow ends the internal reset.

After release, the block produces a CPU clock enable at one eighth of the oscillator rate. It then performs two single-CPU-cycle reads of the start vector, low byte first and high byte second. Finally it drives the assembled start address for one CPU cycle with the opcode fetch strobe raised. The clock-mode outputs always come out of reset as middle-speed, with the sub-clock pin used as a plain input port and its oscillator disabled.

Top module: `rst_vector_seq`

## Requirements
- R1: While the synchronous active-high `rst` input is 1, the block is in internal reset. `int_rst` is 1, and `addr` is 0x0000 with `rd_en`, `fetch_sync` and `cpu_ce` all 0.
- R2: `ext_rst_n` passes through two flip-flops before use. It is honoured only after the synchronised level has been low for MIN_LOW = OSC_MHZ*MIN_PULSE_US consecutive oscillator clocks (16 at the defaults). A shorter low pulse leaves every output unchanged.
- R3: Outside reset, a prescaler divides the oscillator by 16. Each prescaled tick decrements the first counter, which is preloaded with 0xFF and reloads 0xFF when it decrements past zero, so it underflows once every 256 ticks.
- R4: The second counter is preloaded with 0x01 and decrements on each underflow of the first counter. Its underflow releases `int_rst`. `int_rst` therefore reads 0 from the 8195th rising clock edge on which `ext_rst_n` is sampled high: 2 synchroniser edges, 1 qualifier edge and 8192 counting edges.
- R5: `cpu_ce` is a one-clock pulse every 8 oscillator clocks. It is 0 throughout reset hold, and its first pulse comes 8 clocks after the hold ends.
- R6: `mid_speed` and `subclk_port` are 1 whenever `int_rst` is 1 and stay 1 afterwards.
- R7: On release, `addr` shows 0xFFFC with `rd_en` 1 for exactly one CPU cycle (8 clocks). The `rd_data` present on that cycle's `cpu_ce` clock is taken as the low start-address byte.
- R8: Next, `addr` shows 0xFFFD with `rd_en` 1 for one CPU cycle. The `rd_data` present on that cycle's `cpu_ce` clock is taken as the high byte.
- R9: Next, `addr` shows {high byte, low byte} with `rd_en` 1 and `fetch_sync` 1 for one CPU cycle. After that, `addr` holds that value with `rd_en` and `fetch_sync` at 0.
- R10: A qualified low on `ext_rst_n` during any phase of the vector sequence abandons it. `int_rst` returns to 1 and `addr` returns to 0x0000, and a full release and fetch sequence follows the next rise of the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst_n | input | 1 | Raw active-low external reset pin |
| rd_data | input | 8 | Read data returned for the current `addr` |
| addr | output | 16 | Address bus |
| rd_en | output | 1 | Read cycle in progress |
| fetch_sync | output | 1 | First opcode fetch strobe |
| cpu_ce | output | 1 | CPU clock enable, oscillator divided by 8 |
| int_rst | output | 1 | Internal reset to the core |
| mid_speed | output | 1 | Clock mode is middle-speed |
| subclk_port | output | 1 | Sub-clock pin acts as an input port, sub-oscillator disabled |

## Verification
Pin effects are delayed by three register stages: two synchroniser flops and the low-width counter. A qualified assertion is therefore visible on `int_rst` and `addr` three edges after the low level lasts 16 samples. Release follows 8195 edges after the pin is first sampled high. Each vector phase then lasts exactly 8 edges, and the byte is captured on the edge where `cpu_ce` is high. The bench advances a behavioural timeline model on the same rising edge as the design and compares every output a quarter period later. It also measures the pin-rise-to-release edge count directly, so the latency budget is checked on exact cycles.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int unsigned DEF_OSC_MHZ      = 8;
    localparam int unsigned DEF_MIN_PULSE_US = 2;
    localparam int unsigned DEF_PRESC_DIV    = 16;
    localparam int unsigned DEF_CPU_DIV      = 8;
    localparam int unsigned DEF_DATA_W       = 8;

    typedef enum logic [2:0] {
        SQ_WAIT  = 3'd0,
        SQ_VLO   = 3'd1,
        SQ_VHI   = 3'd2,
        SQ_FETCH = 3'd3,
        SQ_RUN   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic mid_speed;
        logic subclk_port;
    } clk_mode_t;

    localparam clk_mode_t MODE_AFTER_RESET = '{mid_speed: 1'b1, subclk_port: 1'b1};

    function automatic int unsigned min_low_cycles(input int unsigned mhz, input int unsigned us);
        return mhz * us;
    endfunction

endpackage

// File: rtl/rstseq_pin_qual.sv
module rstseq_pin_qual #(
    parameter int unsigned MIN_LOW = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic hold_o
);
    localparam int unsigned CW = $clog2(MIN_LOW + 1);

    logic          sync1_q, sync2_q;
    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q   <= 1'b0;
            sync2_q   <= 1'b0;
            low_cnt_q <= CW'(MIN_LOW);
        end else begin
            sync1_q <= pin_n;
            sync2_q <= sync1_q;
            if (sync2_q)
                low_cnt_q <= '0;
            else if (low_cnt_q != CW'(MIN_LOW))
                low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign hold_o = (low_cnt_q == CW'(MIN_LOW));

    // R2: a new hold may only begin after the synchronised pin was low
    a_r2_hold_needs_low: assert property (@(posedge clk) disable iff (rst)
        (hold_o && !$past(hold_o)) |-> !$past(sync2_q));

endmodule

// File: rtl/rstseq_release_timer.sv
module rstseq_release_timer #(
    parameter int unsigned PRESC_DIV = 16,
    parameter int unsigned TW        = 8,
    parameter logic [TW-1:0] T1_PRE  = 8'hFF,
    parameter logic [TW-1:0] T2_PRE  = 8'h01
) (
    input  logic clk,
    input  logic hold,
    output logic release_o
);
    localparam int unsigned PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

    logic [PW-1:0] presc_q;
    logic [TW-1:0] t1_q, t2_q;
    logic          tick, t1_uf, t2_uf;

    assign tick  = (presc_q == PW'(PRESC_DIV - 1));
    assign t1_uf = tick && (t1_q == '0);
    assign t2_uf = t1_uf && (t2_q == '0);

    always_ff @(posedge clk) begin
        if (hold) begin
            presc_q <= '0;
            t1_q    <= T1_PRE;
            t2_q    <= T2_PRE;
        end else begin
            presc_q <= tick ? '0 : presc_q + 1'b1;
            if (tick)
                t1_q <= t1_uf ? T1_PRE : t1_q - 1'b1;
            if (t1_uf)
                t2_q <= t2_uf ? T2_PRE : t2_q - 1'b1;
        end
    end

    assign release_o = t2_uf;

    // R3: the first counter moves only on prescaled ticks
    a_r3_t1_only_on_tick: assert property (@(posedge clk) disable iff (hold)
        !tick |=> $stable(t1_q));

    // R4: a release coincides with the first counter wrapping back to its preload
    a_r4_release_with_t1_wrap: assert property (@(posedge clk) disable iff (hold)
        release_o |=> (t1_q == T1_PRE));

endmodule

// File: rtl/rstseq_vector_fsm.sv
module rstseq_vector_fsm
    import rstseq_pkg::*;
#(
    parameter int unsigned CPU_DIV = 8,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFC
) (
    input  logic              clk,
    input  logic              hold,
    input  logic              release_i,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic              rd_en,
    output logic              fetch_sync,
    output logic              cpu_ce,
    output logic              int_rst
);
    localparam int unsigned DW = (CPU_DIV > 1) ? $clog2(CPU_DIV) : 1;
    localparam logic [ADDR_W-1:0] VEC_HI_ADDR = VEC_ADDR + 1'b1;

    logic [DW-1:0]     phase_q;
    seq_state_e        state_q;
    logic [DATA_W-1:0] lo_q, hi_q;

    assign cpu_ce = !hold && (phase_q == DW'(CPU_DIV - 1));

    always_ff @(posedge clk) begin
        if (hold)
            phase_q <= '0;
        else
            phase_q <= cpu_ce ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (hold) begin
            state_q <= SQ_WAIT;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            unique case (state_q)
                SQ_WAIT:  if (release_i) state_q <= SQ_VLO;
                SQ_VLO:   if (cpu_ce) begin lo_q <= rd_data; state_q <= SQ_VHI; end
                SQ_VHI:   if (cpu_ce) begin hi_q <= rd_data; state_q <= SQ_FETCH; end
                SQ_FETCH: if (cpu_ce) state_q <= SQ_RUN;
                SQ_RUN:   state_q <= SQ_RUN;
                default:  state_q <= SQ_WAIT;
            endcase
        end
    end

    always_comb begin
        addr       = '0;
        rd_en      = 1'b0;
        fetch_sync = 1'b0;
        unique case (state_q)
            SQ_VLO:   begin addr = VEC_ADDR;    rd_en = 1'b1; end
            SQ_VHI:   begin addr = VEC_HI_ADDR; rd_en = 1'b1; end
            SQ_FETCH: begin addr = {hi_q, lo_q}; rd_en = 1'b1; fetch_sync = 1'b1; end
            SQ_RUN:   addr = {hi_q, lo_q};
            default:  addr = '0;
        endcase
    end

    assign int_rst = (state_q == SQ_WAIT);

    // R5: enable pulses are isolated single cycles
    a_r5_ce_single: assert property (@(posedge clk) disable iff (hold)
        cpu_ce |=> !cpu_ce);

    // R4: internal reset only falls after a counter release
    a_r4_fall_after_release: assert property (@(posedge clk) disable iff (hold)
        $fell(int_rst) |-> $past(release_i));

    // R7, R8: the low-byte read is followed by the high-byte read
    a_r8_lo_then_hi: assert property (@(posedge clk) disable iff (hold)
        (rd_en && addr == VEC_ADDR && cpu_ce) |=> (rd_en && addr == VEC_HI_ADDR));

    // R9: the fetch strobe starts right after the high-byte read
    a_r9_sync_after_hi: assert property (@(posedge clk) disable iff (hold)
        $rose(fetch_sync) |-> ($past(addr) == VEC_HI_ADDR));

endmodule

// File: rtl/rst_vector_seq.sv
module rst_vector_seq
    import rstseq_pkg::*;
#(
    parameter int unsigned OSC_MHZ      = DEF_OSC_MHZ,
    parameter int unsigned MIN_PULSE_US = DEF_MIN_PULSE_US,
    parameter int unsigned PRESC_DIV    = DEF_PRESC_DIV,
    parameter int unsigned CPU_DIV      = DEF_CPU_DIV,
    parameter int unsigned DATA_W       = DEF_DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ext_rst_n,
    input  logic [DATA_W-1:0]   rd_data,
    output logic [2*DATA_W-1:0] addr,
    output logic                rd_en,
    output logic                fetch_sync,
    output logic                cpu_ce,
    output logic                int_rst,
    output logic                mid_speed,
    output logic                subclk_port
);
    localparam int unsigned ADDR_W  = 2 * DATA_W;
    localparam int unsigned MIN_LOW = min_low_cycles(OSC_MHZ, MIN_PULSE_US);
    localparam logic [ADDR_W-1:0] VEC_ADDR = {{(ADDR_W-2){1'b1}}, 2'b00};

    logic      pin_hold, hold_any, release_pulse;
    clk_mode_t mode_q;

    assign hold_any = rst | pin_hold;

    rstseq_pin_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .pin_n  (ext_rst_n),
        .hold_o (pin_hold)
    );

    rstseq_release_timer #(
        .PRESC_DIV (PRESC_DIV),
        .TW        (DATA_W),
        .T1_PRE    ({DATA_W{1'b1}}),
        .T2_PRE    (DATA_W'(1))
    ) u_timer (
        .clk       (clk),
        .hold      (hold_any),
        .release_o (release_pulse)
    );

    rstseq_vector_fsm #(
        .CPU_DIV  (CPU_DIV),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .VEC_ADDR (VEC_ADDR)
    ) u_fsm (
        .clk        (clk),
        .hold       (hold_any),
        .release_i  (release_pulse),
        .rd_data    (rd_data),
        .addr       (addr),
        .rd_en      (rd_en),
        .fetch_sync (fetch_sync),
        .cpu_ce     (cpu_ce),
        .int_rst    (int_rst)
    );

    always_ff @(posedge clk) begin
        if (hold_any)
            mode_q <= MODE_AFTER_RESET;
        else
            mode_q <= mode_q;
    end

    assign mid_speed   = mode_q.mid_speed;
    assign subclk_port = mode_q.subclk_port;

    // R6: internal reset always comes with the default clock mode
    a_r6_mode_in_reset: assert property (@(posedge clk) disable iff (rst)
        int_rst |-> (mid_speed && subclk_port));

    // R10: a qualified pin low brings back the internal reset on the next edge
    a_r10_abort: assert property (@(posedge clk) disable iff (rst)
        pin_hold |=> int_rst);

endmodule

// File: tb/tb_rst_vector_seq.sv
module tb_rst_vector_seq;
    localparam int MINL   = 16;
    localparam int REL    = 16 * 256 * 2;   // counting edges until release
    localparam int CPUCYC = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_rst_n = 1'b1;
    logic [7:0]  rd_data;
    logic [15:0] addr;
    logic        rd_en, fetch_sync, cpu_ce, int_rst, mid_speed, subclk_port;

    logic [7:0] vlo = 8'h34, vhi = 8'h12;
    int nchk = 0, nfail = 0, cyc = 0;
    bit checking = 1'b0;

    always #10 clk = ~clk;

    assign rd_data = (addr == 16'hFFFC) ? vlo : (addr == 16'hFFFD) ? vhi : 8'hEA;

    rst_vector_seq dut (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .rd_data(rd_data),
        .addr(addr), .rd_en(rd_en), .fetch_sync(fetch_sync), .cpu_ce(cpu_ce),
        .int_rst(int_rst), .mid_speed(mid_speed), .subclk_port(subclk_port)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural reference model: time since hold ended drives every output
    int   t = 0, lowrun = MINL;
    logic m1 = 1'b0, m2 = 1'b0;
    logic [7:0] mlo = 8'h00, mhi = 8'h00;

    always @(posedge clk) begin
        bit   h;
        logic e_rst, e_ce, e_rd, e_sync;
        logic [15:0] e_addr;
        string tg;
        h = rst || (lowrun == MINL);
        if (h) begin
            t = 0; mlo = 8'h00; mhi = 8'h00;
        end else begin
            if (t == REL + CPUCYC - 1)     mlo = vlo;
            if (t == REL + 2 * CPUCYC - 1) mhi = vhi;
            t = t + 1;
        end
        if (rst) begin
            m1 = 1'b0; m2 = 1'b0; lowrun = MINL;
        end else begin
            if (m2) lowrun = 0;
            else if (lowrun != MINL) lowrun = lowrun + 1;
            m2 = m1; m1 = ext_rst_n;
        end
        e_rst  = (t < REL);
        e_ce   = (t % CPUCYC == CPUCYC - 1);
        e_rd   = (t >= REL) && (t < REL + 3 * CPUCYC);
        e_sync = (t >= REL + 2 * CPUCYC) && (t < REL + 3 * CPUCYC);
        if (t < REL)                   begin e_addr = 16'h0000; tg = (t == 0) ? "R2" : "R4"; end
        else if (t < REL + CPUCYC)     begin e_addr = 16'hFFFC; tg = "R7"; end
        else if (t < REL + 2 * CPUCYC) begin e_addr = 16'hFFFD; tg = "R8"; end
        else                           begin e_addr = {mhi, mlo}; tg = "R9"; end
        #5;
        if (checking) begin
            chk(int_rst === e_rst, (t < 4096) ? "R3" : "R4", "int_rst", int_rst, e_rst);
            chk(cpu_ce === e_ce, "R5", "cpu_ce", cpu_ce, e_ce);
            chk(addr === e_addr, tg, "addr", addr, e_addr);
            chk(rd_en === e_rd, tg, "rd_en", rd_en, e_rd);
            chk(fetch_sync === e_sync, tg, "fetch_sync", fetch_sync, e_sync);
            chk(mid_speed === 1'b1 && subclk_port === 1'b1, "R6", "mode",
                {mid_speed, subclk_port}, 2'b11);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=%0d expected<=200000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int n;
        logic [15:0] run_addr;
        @(posedge clk); checking = 1'b1;
        #5;
        // R1: power-on reset state
        chk(int_rst === 1'b1 && addr === 16'h0000 && rd_en === 1'b0 &&
            fetch_sync === 1'b0 && cpu_ce === 1'b0, "R1", "reset outputs",
            {int_rst, rd_en, fetch_sync, cpu_ce, addr}, {4'b1000, 16'h0000});
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (REL + 60) @(negedge clk);
        run_addr = addr;
        chk(run_addr === 16'h1234, "R9", "first start address", run_addr, 16'h1234);

        // R2: a 15-sample glitch is ignored
        ext_rst_n = 1'b0;
        repeat (MINL - 1) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (30) @(negedge clk);
        chk(addr === run_addr && int_rst === 1'b0, "R2", "glitch ignored",
            {int_rst, addr}, {1'b0, run_addr});

        // R2: exactly MINL samples is honoured
        ext_rst_n = 1'b0;
        repeat (MINL) @(negedge clk);
        vlo = 8'hCD; vhi = 8'hAB;
        repeat (4) @(negedge clk);
        chk(int_rst === 1'b1 && addr === 16'h0000, "R2", "boundary pulse honoured",
            {int_rst, addr}, {1'b1, 16'h0000});
        ext_rst_n = 1'b1;
        // R4: release latency from first high sample
        n = 0;
        do begin
            @(posedge clk); #5; n++;
        end while (int_rst === 1'b1 && n < REL + 100);
        chk(n == REL + 3, "R4", "release latency", n, REL + 3);
        repeat (60) @(negedge clk);
        chk(addr === 16'hABCD, "R9", "second start address", addr, 16'hABCD);

        // R10: abort during the high-byte read
        ext_rst_n = 1'b0;
        repeat (MINL + 4) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (REL + 3 + CPUCYC + 2) @(negedge clk);
        chk(addr === 16'hFFFD && rd_en === 1'b1, "R8", "in high-byte read",
            addr, 16'hFFFD);
        ext_rst_n = 1'b0;
        repeat (MINL + 4) @(negedge clk);
        chk(int_rst === 1'b1 && addr === 16'h0000 && rd_en === 1'b0, "R10",
            "sequence abandoned", {int_rst, rd_en, addr}, {2'b10, 16'h0000});
        vlo = 8'h5A; vhi = 8'hA5;
        ext_rst_n = 1'b1;
        repeat (REL + 60) @(negedge clk);
        chk(addr === 16'hA55A && int_rst === 1'b0, "R10", "restart completes",
            {int_rst, addr}, {1'b0, 16'hA55A});

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule